// File: doc/BRIEF.md
# Sticky Wake-Event Status Register

This block holds the power-management event status of a system as two byte-wide registers on a simple read/write port. The lower byte is kept for status sources that this block does not implement, so it always reads zero. The upper byte records three level-sensitive hardware events: the power button, the sleep button and the real-time clock alarm. Each event bit is sticky. It is set while its input is high and stays set until software clears it by writing a 1 to it.

Bit 7 of the upper byte is a wake flag. It is set when any event whose enable input is high is active while the sleep-state input reports a sleeping state. Software may clear it while the system is working. A clear is refused while the system sleeps and an enabled event is still asserted. Software reads the flags through the combinational read port, and writes 1s to acknowledge them.

Top module: `wake_evt_status`

## Requirements
- R1: After reset is applied, both bytes (offset 0 and offset 1) read 0x00.
- R2: The byte at offset 0 always reads 0x00, and writes to it change nothing in either byte.
- R3: In the byte at offset 1, bit 0 (power button), bit 1 (sleep button) and bit 2 (RTC alarm) each read 1 from the clock edge after their event input is sampled high. They stay 1 after the input falls.
- R4: A write to offset 1 clears each of bits 0 to 2 whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R5: If an event input is high at the same edge as a write-1 clear of its bit, the bit is 1 after that edge.
- R6: Bit 7 of offset 1 (wake) becomes 1 after an edge at which the sleep-state input is non-zero (1 to 5 meaning S1 to S5) and at least one event is both high and enabled. It does not set in state 0 (S0), and it does not set for events whose enable is low.
- R7: With the sleep-state input at 0, writing 1 to bit 7 of offset 1 clears the wake bit.
- R8: While the sleep state is non-zero and an enabled event is high, writing 1 to bit 7 of offset 1 leaves the wake bit at 1.
- R9: Bits 6 to 3 of offset 1 always read 0, including after writes of 1 to them.
- R10: Writes to any address other than offset 1 do not change any status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W (8) | Register byte address |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wdata | input | 8 | Write data; 1 bits clear status flags |
| rdata | output | 8 | Read data for `addr`, combinational |
| evt_lvl | input | NUM_EVT (3) | Event levels: bit 0 power button, bit 1 sleep button, bit 2 RTC alarm |
| evt_en | input | NUM_EVT (3) | Per-event wake enables, same bit order as `evt_lvl` |
| slp_state | input | SLP_W (3) | Sleep state: 0 is working, 1 to 5 are sleep states |

## Verification
Every status bit is a single register stage, and the read path is combinational. An event level or a write seen at one rising edge therefore shows on `rdata` right after that edge, and an address change shows within the same cycle. The bench drives every input on the falling edge, so exactly one rising edge passes. It then samples `rdata` at the next falling edge, after setting the address and a short settle delay. The set-wins and refused-clear cases hold the event input high across the write edge and read back at the next falling edge. This shows that the bit stayed 1 through the edge where a clear would have taken effect.

// File: rtl/wes_pkg.sv
// Shared constants for the wake-event status register.
// Assumes an 8-bit data path and fixed bit positions for the decoded flags.
package wes_pkg;
    localparam int DATA_W  = 8;
    localparam int BIT_WAK = 7;   // wake flag position in the upper byte
    localparam int RSV_LO  = 3;   // lowest always-zero bit of the upper byte
endpackage

// File: rtl/wes_sticky_bit.sv
// One sticky event flag: set by a high event level, cleared by a write-1
// request. Assumes the event input is already synchronous to clk.
module wes_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    output logic q_o
);
    logic flag_q;

    // Hold the flag; the event level takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= evt_i | (flag_q & ~clr_i);
    end

    assign q_o = flag_q;

    a_r3_set_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> q_o);
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_o && !evt_i) |=> !q_o);
    a_r4_hold_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && !clr_i) |=> q_o);
    a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && clr_i && !evt_i) |=> !q_o);
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && clr_i) |=> q_o);
endmodule

// File: rtl/wes_wake_bit.sv
// Wake flag: set while asleep with an enabled event active. A clear is
// refused while that condition still holds. Assumes state 0 means working
// and any non-zero state means asleep.
module wes_wake_bit #(
    parameter int NUM_EVT = 3,
    parameter int SLP_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [NUM_EVT-1:0] en_i,
    input  logic [SLP_W-1:0]   slp_i,
    input  logic               clr_req_i,
    output logic               q_o
);
    logic asleep;
    logic armed;
    logic clr_ok;
    logic wake_q;

    // Decode the sleep state and the OR of enabled active events.
    always_comb begin
        asleep = (slp_i != '0);
        armed  = |(evt_i & en_i);
        clr_ok = clr_req_i & ~(asleep & armed);
    end

    // Update the wake flag.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= (asleep & armed) | (wake_q & ~clr_ok);
    end

    assign q_o = wake_q;

    a_r6_set_when_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && armed) |=> q_o);
    a_r6_no_set_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_o && !(asleep && armed)) |=> !q_o);
    a_r7_clear_when_awake: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && clr_req_i && !asleep) |=> !q_o);
    a_r8_refuse_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && clr_req_i && asleep && armed) |=> q_o);
endmodule

// File: rtl/wes_read_mux.sv
// Read-data selection for the two status bytes. The lower byte and the
// reserved bits of the upper byte are tied to zero. Assumes NUM_EVT <= 3.
module wes_read_mux
    import wes_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LO_OFS  = 0,
    parameter int HI_OFS  = 1,
    parameter int NUM_EVT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NUM_EVT-1:0] evt_q_i,
    input  logic              wak_q_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] hi_byte;

    // Assemble the upper byte from the flag registers.
    always_comb begin
        hi_byte          = '0;
        hi_byte[BIT_WAK] = wak_q_i;
        for (int i = 0; i < NUM_EVT; i++) hi_byte[i] = evt_q_i[i];
    end

    // Select the byte addressed; unknown and low offsets read zero.
    always_comb begin
        if (addr_i == ADDR_W'(HI_OFS)) rdata_o = hi_byte;
        else                           rdata_o = '0;
    end

    a_r2_low_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_W'(LO_OFS)) |-> (rdata_o == '0));
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_W'(HI_OFS)) |-> (rdata_o[BIT_WAK-1:RSV_LO] == '0));
endmodule

// File: rtl/wake_evt_status.sv
// Top of the wake-event status register: three sticky event flags, the
// wake flag and the read path. The write decode turns write-1 bits at the
// upper offset into clear requests. Assumes all inputs are synchronous to clk.
module wake_evt_status
    import wes_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LO_OFS  = 0,
    parameter int HI_OFS  = 1,
    parameter int NUM_EVT = 3,
    parameter int SLP_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    input  logic [NUM_EVT-1:0] evt_lvl,
    input  logic [NUM_EVT-1:0] evt_en,
    input  logic [SLP_W-1:0]   slp_state
);
    logic               hi_wr;
    logic [NUM_EVT-1:0] evt_clr;
    logic [NUM_EVT-1:0] evt_q;
    logic               wak_q;

    // Decode writes to the upper byte into per-bit clear requests.
    always_comb begin
        hi_wr   = wr_en & (addr == ADDR_W'(HI_OFS));
        evt_clr = {NUM_EVT{hi_wr}} & wdata[NUM_EVT-1:0];
    end

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        wes_sticky_bit u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .evt_i (evt_lvl[g]),
            .clr_i (evt_clr[g]),
            .q_o   (evt_q[g])
        );
    end

    wes_wake_bit #(.NUM_EVT(NUM_EVT), .SLP_W(SLP_W)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_lvl),
        .en_i      (evt_en),
        .slp_i     (slp_state),
        .clr_req_i (hi_wr & wdata[BIT_WAK]),
        .q_o       (wak_q)
    );

    wes_read_mux #(
        .ADDR_W(ADDR_W), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS), .NUM_EVT(NUM_EVT)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (addr),
        .evt_q_i (evt_q),
        .wak_q_i (wak_q),
        .rdata_o (rdata)
    );

    // R10: flags hold when no write hits the upper byte and no event is high.
    a_r10_other_addr_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_wr && evt_lvl == '0 && evt_q[0]) |=> evt_q[0]);
endmodule

// File: tb/wake_evt_status_test.sv
// Directed bench for wake_evt_status: one task per scenario.
module wake_evt_status_test;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [2:0] evt_lvl = 3'd0;
    logic [2:0] evt_en = 3'd0;
    logic [2:0] slp_state = 3'd0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    wake_evt_status uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .evt_lvl(evt_lvl), .evt_en(evt_en), .slp_state(slp_state)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // Write one byte; returns at the falling edge after the write edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Hold the given event levels for exactly one rising edge.
    task automatic pulse(input logic [2:0] e);
        @(negedge clk);
        evt_lvl = e;
        @(negedge clk);
        evt_lvl = 3'd0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(8'd0, d); check("R1 low after reset", d, 8'h00);
        rd(8'd1, d); check("R1 high after reset", d, 8'h00);
        pulse(3'b011);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(8'd1, d); check("R1 high after mid-run reset", d, 8'h00);
    endtask

    task automatic t_low_byte;
        logic [7:0] d;
        slp_state = 3'd0; evt_en = 3'd0;
        pulse(3'b111);
        wr(8'd0, 8'hFF);
        rd(8'd0, d); check("R2 low byte stays zero", d, 8'h00);
        rd(8'd1, d); check("R2 write to low leaves high", d, 8'h07);
        wr(8'd1, 8'h07);
    endtask

    task automatic t_sticky;
        logic [7:0] d;
        pulse(3'b001);
        rd(8'd1, d); check("R3 power button sticky", d, 8'h01);
        pulse(3'b100);
        rd(8'd1, d); check("R3 rtc alarm sticky", d, 8'h05);
        pulse(3'b010);
        rd(8'd1, d); check("R3 sleep button sticky", d, 8'h07);
        wr(8'd1, 8'h00);
        rd(8'd1, d); check("R4 write zero no effect", d, 8'h07);
        wr(8'd1, 8'h01);
        rd(8'd1, d); check("R4 clear bit 0 only", d, 8'h06);
        wr(8'd1, 8'h06);
        rd(8'd1, d); check("R4 clear bits 1 and 2", d, 8'h00);
    endtask

    task automatic t_set_wins;
        logic [7:0] d;
        @(negedge clk);
        evt_lvl = 3'b010;
        addr = 8'd1; wdata = 8'h02; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; evt_lvl = 3'd0;
        rd(8'd1, d); check("R5 set beats clear", d, 8'h02);
        wr(8'd1, 8'h02);
        rd(8'd1, d); check("R5 clear after event low", d, 8'h00);
    endtask

    task automatic t_wake;
        logic [7:0] d;
        slp_state = 3'd3; evt_en = 3'b100;
        pulse(3'b001);
        rd(8'd1, d); check("R6 disabled event no wake", d, 8'h01);
        wr(8'd1, 8'h01);
        slp_state = 3'd0; evt_en = 3'b111;
        pulse(3'b100);
        rd(8'd1, d); check("R6 no wake in S0", d, 8'h04);
        wr(8'd1, 8'h04);
        slp_state = 3'd5; evt_en = 3'b100;
        pulse(3'b100);
        rd(8'd1, d); check("R6 wake set asleep", d, 8'h84);
        wr(8'd1, 8'h04);
        // Hold the enabled event high across a wake clear while asleep.
        @(negedge clk);
        evt_lvl = 3'b100;
        addr = 8'd1; wdata = 8'h80; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd(8'd1, d); check("R8 clear refused asleep", d & 8'h80, 8'h80);
        evt_lvl = 3'd0;
        @(negedge clk);
        slp_state = 3'd0;
        wr(8'd1, 8'h80);
        rd(8'd1, d); check("R7 wake cleared in S0", d, 8'h04);
        wr(8'd1, 8'h04);
        rd(8'd1, d); check("R7 all clear", d, 8'h00);
    endtask

    task automatic t_reserved;
        logic [7:0] d;
        evt_en = 3'd0;
        pulse(3'b001);
        wr(8'd1, 8'h78);
        rd(8'd1, d); check("R9 reserved bits read zero", d, 8'h01);
        wr(8'd2, 8'hFF);
        rd(8'd1, d); check("R10 write other address ignored", d, 8'h01);
        wr(8'd3, 8'h01);
        rd(8'd1, d); check("R10 second address ignored", d, 8'h01);
        wr(8'd1, 8'h01);
        rd(8'd1, d); check("R4 final clear", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_low_byte();
        t_sticky();
        t_set_wins();
        t_wake();
        t_reserved();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule